// File: doc/BRIEF.md
# Segment Access Guard

This block judges one memory access against a descriptor that a processor already holds in a cache. Each request carries the descriptor fields: base, a 20-bit limit, the granularity flag, the operand-size flag, the present bit, the code/data flag, the executable, direction/conforming and read/write bits, and the descriptor privilege. It also carries the access offset, a byte count, the access kind and the current privilege level. One clock later the block returns the linear address, a pass flag and a fault code.

The limit test scales the limit by the granularity. It treats data segments whose direction bit is set as expand-down, and it checks every byte that the access touches. The rights test splits on code versus data. The privilege test uses one rule for loads and stores and a separate pair of rules for far transfers into conforming or non-conforming code. Gates, system descriptors and paging belong to other blocks.

Top module: `seg_guard`

## Requirements
- R1: Outputs are registered. `rsp_valid` equals the previous cycle's `req_valid`, and `lin_addr`, `acc_ok` and `fault_code` reflect the request captured on that edge. Reset drives all four outputs to zero.
- R2: `lin_addr` is `desc_base + acc_off` modulo 2^32.
- R3: With `desc_gran`=0 the effective limit is the 20-bit limit in bytes. With `desc_gran`=1 it is limit*4096 + 4095, so limit 0xFFFFF covers all 4 GiB.
- R4: `acc_len` holds the byte count minus one (0..3). For code segments, and for data segments with the direction bit 0, an access is in range only if every byte from `acc_off` to `acc_off+acc_len` is at or below the effective limit. Bytes past 2^32-1 are out of range.
- R5: For a data segment (`desc_exec`=0) with the direction bit 1, every touched byte must be strictly above the effective limit and no higher than 0xFFFF when `desc_big`=0, or 0xFFFFFFFF when `desc_big`=1.
- R6: Data segments (`desc_exec`=0): reads (`acc_kind`=0) are always permitted, writes (`acc_kind`=1) need `desc_rw`=1, and execute (`acc_kind`=2) is a rights fault.
- R7: Code segments (`desc_exec`=1): writes are always a rights fault, reads need `desc_rw`=1, and execute is permitted.
- R8: A descriptor with `desc_is_seg`=0 gives a rights fault for every access. The reserved kind `acc_kind`=3 is also a rights fault.
- R9: For reads and writes, the access passes the privilege test only when `desc_dpl` >= `cpl` numerically (ring 0 is the most privileged).
- R10: For execute into code, conforming code (`desc_dc`=1) needs `cpl` >= `desc_dpl`, and non-conforming code needs `cpl` == `desc_dpl`.
- R11: `fault_code` is 0 none, 1 limit, 2 rights, 3 privilege, 4 not present, chosen in the order not present, rights, privilege, limit. `acc_ok` is 1 exactly when the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | 0 byte units, 1 4 KiB units |
| desc_big | input | 1 | 0 16-bit segment, 1 32-bit segment |
| desc_present | input | 1 | Descriptor present |
| desc_is_seg | input | 1 | 1 code/data descriptor, 0 system |
| desc_exec | input | 1 | 1 code, 0 data |
| desc_dc | input | 1 | Expand-down (data) or conforming (code) |
| desc_rw | input | 1 | Writable (data) or readable (code) |
| desc_dpl | input | 2 | Descriptor privilege level |
| acc_off | input | 32 | Access offset |
| acc_len | input | 2 | Bytes touched minus one |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| acc_ok | output | 1 | Access permitted |
| fault_code | output | 3 | Fault reason |

## Verification
One sweep covers every combination of the present, code/data, executable, direction and read/write bits with all four access kinds and all sixteen pairs of current and descriptor privilege. It separates the rights rules from the privilege rules and shows which fault wins when several apply. A second sweep places the offset a few bytes either side of the scaled limit, the 16-bit top and the 4 GiB top, with every access length, under both granularities and both expand directions. This tells apart an off-by-one at the limit, a missing page scale, a wrong 16-bit bound and an end address that wraps. The base varies in every request, so an error in the linear address shows up for many offsets.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_LIMIT  = 3'd1,
    FLT_RIGHTS = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_ABSENT = 3'd4
  } fault_e;

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 20,
  parameter int LEN_W   = 2,
  parameter int SMALL_W = 16
) (
  input  logic [LIM_W-1:0]  limit,
  input  logic              gran,
  input  logic              big,
  input  logic              expand_down,
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0]  len_m1,
  output logic              out_of_range
);
  localparam int PG_SHIFT = ADDR_W - LIM_W;
  localparam int EXT_W    = ADDR_W + 1;

  // Scaled limit: byte units, or page units with the low page bits filled
  function automatic logic [ADDR_W-1:0] f_scaled_limit(
    input logic [LIM_W-1:0] lim, input logic g);
    if (g) return {lim, {PG_SHIFT{1'b1}}};
    return {{PG_SHIFT{1'b0}}, lim};
  endfunction

  // Address of the last touched byte, one extra bit to catch wrap
  function automatic logic [EXT_W-1:0] f_last_byte(
    input logic [ADDR_W-1:0] o, input logic [LEN_W-1:0] l);
    return {1'b0, o} + EXT_W'(l);
  endfunction

  logic [ADDR_W-1:0] eff_lim;
  logic [EXT_W-1:0]  last_b;
  logic [EXT_W-1:0]  top_b;
  logic              up_bad;
  logic              down_bad;

  assign eff_lim  = f_scaled_limit(limit, gran);
  assign last_b   = f_last_byte(off, len_m1);
  assign top_b    = big ? {1'b0, {ADDR_W{1'b1}}} : EXT_W'({SMALL_W{1'b1}});
  assign up_bad   = last_b > {1'b0, eff_lim};
  assign down_bad = (off <= eff_lim) || (last_b > top_b);

  assign out_of_range = expand_down ? down_bad : up_bad;
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
  import seg_guard_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            is_seg,
  input  logic            exec,
  input  logic            dc,
  input  logic            rw,
  input  logic [1:0]      kind,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] dpl,
  output logic            rights_bad,
  output logic            priv_bad
);
  acc_kind_e k;
  assign k = acc_kind_e'(kind);

  // Rights: code vs data split, system descriptors always refused
  function automatic logic f_rights_bad(
    input logic s, input logic x, input logic w, input acc_kind_e a);
    if (!s) return 1'b1;
    case (a)
      ACC_READ:  return x ? !w : 1'b0;
      ACC_WRITE: return x ? 1'b1 : !w;
      ACC_EXEC:  return !x;
      default:   return 1'b1;
    endcase
  endfunction

  // Privilege: far transfer rules for code, numeric rule for loads/stores
  function automatic logic f_priv_bad(
    input logic conf, input acc_kind_e a,
    input logic [PL_W-1:0] c, input logic [PL_W-1:0] d);
    if (a == ACC_EXEC) return conf ? (c < d) : (c != d);
    return d < c;
  endfunction

  assign rights_bad = f_rights_bad(is_seg, exec, rw, k);
  assign priv_bad   = f_priv_bad(dc, k, cpl, dpl);
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 20,
  parameter int LEN_W   = 2,
  parameter int PL_W    = 2,
  parameter int SMALL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [LIM_W-1:0]  desc_limit,
  input  logic              desc_gran,
  input  logic              desc_big,
  input  logic              desc_present,
  input  logic              desc_is_seg,
  input  logic              desc_exec,
  input  logic              desc_dc,
  input  logic              desc_rw,
  input  logic [PL_W-1:0]   desc_dpl,
  input  logic [ADDR_W-1:0] acc_off,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [1:0]        acc_kind,
  input  logic [PL_W-1:0]   cpl,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              acc_ok,
  output logic [2:0]        fault_code
);
  function automatic logic [ADDR_W-1:0] f_linear(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] o);
    return b + o;
  endfunction

  logic   hit_limit;
  logic   hit_rights;
  logic   hit_priv;
  fault_e fault_next;

  seg_limit_unit #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .LEN_W(LEN_W), .SMALL_W(SMALL_W)
  ) u_limit (
    .limit       (desc_limit),
    .gran        (desc_gran),
    .big         (desc_big),
    .expand_down (desc_dc & ~desc_exec),
    .off         (acc_off),
    .len_m1      (acc_len),
    .out_of_range(hit_limit)
  );

  seg_rights_unit #(.PL_W(PL_W)) u_rights (
    .is_seg    (desc_is_seg),
    .exec      (desc_exec),
    .dc        (desc_dc),
    .rw        (desc_rw),
    .kind      (acc_kind),
    .cpl       (cpl),
    .dpl       (desc_dpl),
    .rights_bad(hit_rights),
    .priv_bad  (hit_priv)
  );

  always_comb begin
    if (!desc_present)   fault_next = FLT_ABSENT;
    else if (hit_rights) fault_next = FLT_RIGHTS;
    else if (hit_priv)   fault_next = FLT_PRIV;
    else if (hit_limit)  fault_next = FLT_LIMIT;
    else                 fault_next = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      lin_addr   <= '0;
      acc_ok     <= 1'b0;
      fault_code <= 3'd0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        lin_addr   <= f_linear(desc_base, acc_off);
        acc_ok     <= (fault_next == FLT_NONE);
        fault_code <= fault_next;
      end
    end
  end
endmodule

// File: rtl/seg_guard_sva.sv
module seg_guard_sva #(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] desc_base,
  input logic              desc_present,
  input logic              desc_is_seg,
  input logic              desc_exec,
  input logic              desc_dc,
  input logic              desc_rw,
  input logic [PL_W-1:0]   desc_dpl,
  input logic [ADDR_W-1:0] acc_off,
  input logic [1:0]        acc_kind,
  input logic [PL_W-1:0]   cpl,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] lin_addr,
  input logic              acc_ok,
  input logic [2:0]        fault_code,
  input logic              hit_limit,
  input logic              hit_rights,
  input logic              hit_priv
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_linear_sum: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_addr == ($past(desc_base) + $past(acc_off)));

  a_r11_ok_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (acc_ok == (fault_code == 3'd0)));

  a_r11_absent_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !desc_present) |=> fault_code == 3'd4);

  a_r11_rights_before_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && hit_rights) |=> fault_code == 3'd2);

  a_r11_limit_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && !hit_rights && !hit_priv && hit_limit)
      |=> fault_code == 3'd1);

  a_r7_code_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && desc_is_seg && desc_exec && acc_kind == 2'd1)
      |=> fault_code == 3'd2);

  a_r6_data_read_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && desc_is_seg && !desc_exec && acc_kind == 2'd0)
      |=> fault_code != 3'd2);

  a_r6_data_write_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && desc_is_seg && !desc_exec && desc_rw && acc_kind == 2'd1)
      |=> fault_code != 3'd2);

  a_r10_nonconforming_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && desc_is_seg && desc_exec && !desc_dc &&
     acc_kind == 2'd2 && cpl != desc_dpl) |=> fault_code == 3'd3);
endmodule

bind seg_guard seg_guard_sva #(.ADDR_W(ADDR_W), .PL_W(PL_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .desc_base   (desc_base),
  .desc_present(desc_present),
  .desc_is_seg (desc_is_seg),
  .desc_exec   (desc_exec),
  .desc_dc     (desc_dc),
  .desc_rw     (desc_rw),
  .desc_dpl    (desc_dpl),
  .acc_off     (acc_off),
  .acc_kind    (acc_kind),
  .cpl         (cpl),
  .rsp_valid   (rsp_valid),
  .lin_addr    (lin_addr),
  .acc_ok      (acc_ok),
  .fault_code  (fault_code),
  .hit_limit   (hit_limit),
  .hit_rights  (hit_rights),
  .hit_priv    (hit_priv)
);

// File: tb/seg_guard_bench.sv
`timescale 1ns/1ps
module seg_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] desc_base = '0;
  logic [19:0] desc_limit = '0;
  logic        desc_gran = 1'b0, desc_big = 1'b0, desc_present = 1'b0;
  logic        desc_is_seg = 1'b0, desc_exec = 1'b0, desc_dc = 1'b0, desc_rw = 1'b0;
  logic [1:0]  desc_dpl = '0;
  logic [31:0] acc_off = '0;
  logic [1:0]  acc_len = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  cpl = '0;
  logic        rsp_valid;
  logic [31:0] lin_addr;
  logic        acc_ok;
  logic [2:0]  fault_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  seg_guard u_seg_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
    .desc_big(desc_big), .desc_present(desc_present), .desc_is_seg(desc_is_seg),
    .desc_exec(desc_exec), .desc_dc(desc_dc), .desc_rw(desc_rw),
    .desc_dpl(desc_dpl), .acc_off(acc_off), .acc_len(acc_len),
    .acc_kind(acc_kind), .cpl(cpl), .rsp_valid(rsp_valid),
    .lin_addr(lin_addr), .acc_ok(acc_ok), .fault_code(fault_code)
  );

  task automatic check(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Byte-by-byte range test, restated from R3, R4 and R5
  function automatic bit range_ok();
    longint eff, top, b;
    eff = desc_gran ? (longint'(desc_limit) * 4096 + 4095) : longint'(desc_limit);
    top = desc_big ? 64'hFFFF_FFFF : 64'hFFFF;
    for (int i = 0; i <= int'(acc_len); i++) begin
      b = longint'(acc_off) + i;
      if (!desc_exec && desc_dc) begin
        if (b <= eff || b > top) return 0;
      end else begin
        if (b > eff) return 0;
      end
    end
    return 1;
  endfunction

  function automatic int expected_code();
    bit r_ok, p_ok;
    int d, c;
    d = int'(desc_dpl);
    c = int'(cpl);
    if (!desc_present) return 4;
    if (!desc_is_seg || acc_kind == 2'd3) r_ok = 0;
    else if (acc_kind == 2'd2) r_ok = desc_exec;
    else if (acc_kind == 2'd1) r_ok = !desc_exec && desc_rw;
    else r_ok = !desc_exec || desc_rw;
    if (!r_ok) return 2;
    if (acc_kind == 2'd2) p_ok = desc_dc ? (c >= d) : (c == d);
    else p_ok = (d >= c);
    if (!p_ok) return 3;
    if (!range_ok()) return 1;
    return 0;
  endfunction

  task automatic issue_and_check(string tag);
    int exp;
    longint lin;
    exp = expected_code();
    lin = (longint'(desc_base) + longint'(acc_off)) & 64'hFFFF_FFFF;
    req_valid = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid", rsp_valid, 1);
    check("R2", "lin_addr", lin_addr, lin);
    check(tag, "fault_code", fault_code, exp);
    check("R11", "acc_ok", acc_ok, exp == 0);
  endtask

  function automatic logic [31:0] pick_off(int idx, longint eff);
    case (idx)
      0, 1, 2, 3, 4: return 32'((eff - 2 + idx) & 64'hFFFF_FFFF);
      5:  return 32'h0;
      6:  return 32'hFFFC;
      7:  return 32'hFFFD;
      8:  return 32'h1_0000;
      9:  return 32'hFFFF_FFFD;
      10: return 32'hFFFF_FFFF;
      default: return 32'h8000;
    endcase
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset rsp_valid", rsp_valid, 0);
    check("R1", "reset lin_addr", lin_addr, 0);
    check("R1", "reset acc_ok", acc_ok, 0);
    check("R1", "reset fault_code", fault_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle rsp_valid", rsp_valid, 0);

    // Sweep of type bits, kinds and privilege pairs: R6 R7 R8 R9 R10 R11
    n = 0;
    desc_limit = 20'hFFFFF; desc_gran = 1'b1; desc_big = 1'b1;
    acc_off = 32'h0000_0100; acc_len = 2'd1;
    for (int t = 0; t < 32; t++) begin
      for (int k = 0; k < 4; k++) begin
        for (int pr = 0; pr < 16; pr++) begin
          string tag;
          {desc_present, desc_is_seg, desc_exec, desc_dc, desc_rw} = 5'(t);
          acc_kind = 2'(k);
          cpl = 2'(pr >> 2);
          desc_dpl = 2'(pr);
          desc_base = 32'h9E37_79B9 * 32'(n);
          n++;
          if (!desc_present) tag = "R11";
          else if (!desc_is_seg || k == 3) tag = "R8";
          else if (desc_exec) tag = (k == 2) ? "R10" : "R7";
          else tag = (k == 1) ? "R6 R9" : "R9";
          issue_and_check(tag);
        end
      end
    end

    // Boundary sweep of the limit logic: R3 R4 R5
    desc_present = 1'b1; desc_is_seg = 1'b1; desc_exec = 1'b0; desc_rw = 1'b1;
    desc_dpl = 2'd0; cpl = 2'd0; acc_kind = 2'd0;
    for (int g = 0; g < 2; g++) begin
      for (int li = 0; li < 4; li++) begin
        for (int dv = 0; dv < 2; dv++) begin
          for (int bv = 0; bv < 2; bv++) begin
            for (int oi = 0; oi < 12; oi++) begin
              for (int ln = 0; ln < 4; ln++) begin
                longint eff;
                desc_gran = g[0];
                case (li)
                  0: desc_limit = 20'h0;
                  1: desc_limit = 20'h12;
                  2: desc_limit = 20'h0FFFF;
                  default: desc_limit = 20'hFFFFF;
                endcase
                desc_dc = dv[0];
                desc_big = bv[0];
                eff = g ? (longint'(desc_limit) * 4096 + 4095) : longint'(desc_limit);
                acc_off = pick_off(oi, eff);
                acc_len = 2'(ln);
                desc_base = 32'hC0DE_0000 + 32'(n * 7);
                n++;
                issue_and_check(dv ? "R5" : (g ? "R3" : "R4"));
              end
            end
          end
        end
      end
    end

    // R1: response drops after the request is removed
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", "rsp_valid after idle", rsp_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule